// File: doc/BRIEF.md
# SMI Generation Enable Controller

This block decides when the platform raises a system management interrupt (SMI) request toward the processor. Software programs a power-management I/O base through a small configuration window. It then reaches an SMI enable register, a source status register and a periodic divider register inside the I/O window that starts at that base. Three sources can raise a request: a write to the fixed software SMI command port, a periodic divider, and any attempt to turn on the flash write-enable bit in the flash control register.

The flash write-enable bit is the point the protection scheme depends on. While SMIs are enabled, an attempt to set it raises a request so that the SMM handler can inspect the attempt and clear the bit again. While the global enable is clear, the bit simply stays set. A write-once lock in the general power-management register freezes the global enable so that this bypass cannot be armed. A separate protect bit limits flash writes to times when the processor reports that it is in SMM.

Top module: `smi_gen_ctrl`

## Requirements
- R1: After reset the SMI enable register reads 0x7 (global bit 0, software-port bit 1, periodic bit 2 all set). The status register, the lock, the flash control register and the I/O base read 0. smi_req and flash_wr_ok are low.
- R2: Configuration offset 0x40 holds the I/O base in bits 15:7. The enable register sits at base+0x30, the status register at base+0x34 and the periodic divider (bits 15:0) at base+0x38. I/O writes outside the window do not change these registers.
- R3: While enable bit 0 is clear, smi_req never rises from any source, but source status bits are still recorded.
- R4: A write to I/O address 0xB2 with enable bit 1 set sets status bit 1 and raises smi_req after the write cycle when the global enable is set. With enable bit 1 clear, it sets neither.
- R5: With enable bit 2 set and divider value P, status bit 2 is set once every P+1 clock cycles. With enable bit 2 clear, the divider is held and status bit 2 stays clear.
- R6: A configuration write to offset 0xDC with bit 0 set while that bit is clear is a flash attempt. It sets the bit and status bit 3 in all cases, and it raises smi_req when the global enable is set. Writing 0 clears the bit.
- R7: Configuration offset 0xA0 bit 4 is a lock that can be set once and is cleared only by reset. While it is set, writes leave enable bit 0 unchanged, and the other enable bits stay writable.
- R8: smi_req is a level that holds until smm_ack is seen. If a new source event falls in the same cycle as smm_ack, smi_req stays asserted.
- R9: Status bits clear when 1 is written to them and are unchanged by writing 0. A source event in the same cycle as a clearing write leaves the bit set.
- R10: flash_wr_ok is high only when bit 0 of offset 0xDC is set, and either bit 1 of offset 0xDC (SMM-only protect) is clear or smm_active is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data for io_addr (combinational) |
| smm_ack | input | 1 | Processor acknowledges the SMI request |
| smm_active | input | 1 | Processor is executing in SMM |
| smi_req | output | 1 | SMI request level |
| flash_wr_ok | output | 1 | Flash writes currently permitted |

## Verification
Two pairs of events can fall in the same clock cycle. An SMM acknowledge can arrive in the same cycle as a new software-port write. A clearing write to the status register can arrive in the same cycle as a flash attempt on the configuration port. The bench drives both inputs of each pair on the same falling edge and holds them for one cycle. It then judges the result by the request level, which must stay high, and by a status read, which must still show bit 3.

// File: rtl/smi_gen_pkg.sv
package smi_gen_pkg;
  // Configuration space offsets
  localparam logic [7:0] CFG_PMBASE = 8'h40;
  localparam logic [7:0] CFG_GENPM  = 8'hA0;
  localparam logic [7:0] CFG_FLASH  = 8'hDC;

  // Offsets inside the power-management I/O window
  localparam logic [6:0] OFS_ENABLE = 7'h30;
  localparam logic [6:0] OFS_STATUS = 7'h34;
  localparam logic [6:0] OFS_PERIOD = 7'h38;

  // Bit positions
  localparam int BIT_GLB      = 0;
  localparam int BIT_SW       = 1;
  localparam int BIT_PER      = 2;
  localparam int BIT_FL       = 3;
  localparam int BIT_LOCK     = 4;
  localparam int BIT_WREN     = 0;
  localparam int BIT_SMM_ONLY = 1;

  typedef struct packed {
    logic fl;
    logic per;
    logic sw;
  } smi_src_t;
endpackage

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
  import smi_gen_pkg::*;
#(
  parameter int IO_AW    = 16,
  parameter int BASE_LSB = 7,
  parameter int DATA_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [7:0]                cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  output logic [DATA_W-1:0]         cfg_rdata,
  output logic [IO_AW-1:BASE_LSB]   pm_base,
  output logic                      smi_lock,
  output logic                      fl_wren,
  output logic                      fl_smm_only,
  output logic                      fl_attempt
);
  localparam int BASE_W = IO_AW - BASE_LSB;

  logic [BASE_W-1:0] base_q, base_nx;
  logic              lock_q, lock_nx;
  logic              wren_q, wren_nx;
  logic              smmo_q, smmo_nx;
  logic              wr_base, wr_genpm, wr_flash;

  assign wr_base  = cfg_wr && (cfg_addr == CFG_PMBASE);
  assign wr_genpm = cfg_wr && (cfg_addr == CFG_GENPM);
  assign wr_flash = cfg_wr && (cfg_addr == CFG_FLASH);

  // Next-state logic
  always_comb begin
    base_nx = base_q;
    lock_nx = lock_q;
    wren_nx = wren_q;
    smmo_nx = smmo_q;
    if (wr_base) base_nx = cfg_wdata[IO_AW-1:BASE_LSB];
    // write-once: only a set is accepted, never a clear
    if (wr_genpm && cfg_wdata[BIT_LOCK]) lock_nx = 1'b1;
    if (wr_flash) begin
      wren_nx = cfg_wdata[BIT_WREN];
      smmo_nx = cfg_wdata[BIT_SMM_ONLY];
    end
  end

  assign fl_attempt = wr_flash && cfg_wdata[BIT_WREN] && !wren_q;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lock_q <= 1'b0;
      wren_q <= 1'b0;
      smmo_q <= 1'b0;
    end else begin
      base_q <= base_nx;
      lock_q <= lock_nx;
      wren_q <= wren_nx;
      smmo_q <= smmo_nx;
    end
  end

  // Read mux
  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      CFG_PMBASE: cfg_rdata[IO_AW-1:BASE_LSB] = base_q;
      CFG_GENPM:  cfg_rdata[BIT_LOCK]         = lock_q;
      CFG_FLASH: begin
        cfg_rdata[BIT_WREN]     = wren_q;
        cfg_rdata[BIT_SMM_ONLY] = smmo_q;
      end
      default:    cfg_rdata = '0;
    endcase
  end

  assign pm_base     = base_q;
  assign smi_lock    = lock_q;
  assign fl_wren     = wren_q;
  assign fl_smm_only = smmo_q;

  logic unused_cfg;
  assign unused_cfg = ^{cfg_wdata[DATA_W-1:IO_AW], cfg_wdata[BASE_LSB-1:5], cfg_wdata[3:2]};
endmodule

// File: rtl/smi_io_regs.sv
module smi_io_regs
  import smi_gen_pkg::*;
#(
  parameter int              IO_AW    = 16,
  parameter int              BASE_LSB = 7,
  parameter int              DATA_W   = 32,
  parameter int              DIV_W    = 16,
  parameter logic [DIV_W-1:0] PER_RST = '1,
  parameter logic [IO_AW-1:0] SWPORT  = 16'h00B2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    io_wr,
  input  logic [IO_AW-1:0]        io_addr,
  input  logic [DATA_W-1:0]       io_wdata,
  output logic [DATA_W-1:0]       io_rdata,
  input  logic [IO_AW-1:BASE_LSB] pm_base,
  input  logic                    smi_lock,
  input  logic                    fl_attempt,
  input  logic                    per_tick,
  output logic                    glb_en,
  output logic                    per_en,
  output logic [DIV_W-1:0]        period,
  output smi_src_t                events
);
  logic in_win, hit_en_w, hit_sts_w, hit_per_w, sw_hit;
  logic [BASE_LSB-1:0] ofs;

  logic glb_q, glb_nx, sw_q, sw_nx, per_q, per_nx;
  smi_src_t sts_q, sts_nx, sts_clr;
  logic [DIV_W-1:0] div_q, div_nx;

  assign ofs       = io_addr[BASE_LSB-1:0];
  assign in_win    = (io_addr[IO_AW-1:BASE_LSB] == pm_base);
  assign hit_en_w  = io_wr && in_win && (ofs == BASE_LSB'(OFS_ENABLE));
  assign hit_sts_w = io_wr && in_win && (ofs == BASE_LSB'(OFS_STATUS));
  assign hit_per_w = io_wr && in_win && (ofs == BASE_LSB'(OFS_PERIOD));
  assign sw_hit    = io_wr && (io_addr == SWPORT);

  // Source events, each qualified by its own enable
  assign events.sw  = sw_hit && sw_q;
  assign events.per = per_tick && per_q;
  assign events.fl  = fl_attempt;

  assign sts_clr.sw  = hit_sts_w && io_wdata[BIT_SW];
  assign sts_clr.per = hit_sts_w && io_wdata[BIT_PER];
  assign sts_clr.fl  = hit_sts_w && io_wdata[BIT_FL];

  // Next-state logic
  always_comb begin
    glb_nx = glb_q;
    sw_nx  = sw_q;
    per_nx = per_q;
    div_nx = div_q;
    if (hit_en_w) begin
      if (!smi_lock) glb_nx = io_wdata[BIT_GLB];
      sw_nx  = io_wdata[BIT_SW];
      per_nx = io_wdata[BIT_PER];
    end
    if (hit_per_w) div_nx = io_wdata[DIV_W-1:0];
    // a new event wins over a clearing write in the same cycle
    sts_nx = (sts_q & ~sts_clr) | events;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= 1'b1;
      sw_q  <= 1'b1;
      per_q <= 1'b1;
      sts_q <= '0;
      div_q <= PER_RST;
    end else begin
      glb_q <= glb_nx;
      sw_q  <= sw_nx;
      per_q <= per_nx;
      sts_q <= sts_nx;
      div_q <= div_nx;
    end
  end

  // Read mux
  always_comb begin
    io_rdata = '0;
    if (in_win) begin
      case (ofs)
        BASE_LSB'(OFS_ENABLE): begin
          io_rdata[BIT_GLB] = glb_q;
          io_rdata[BIT_SW]  = sw_q;
          io_rdata[BIT_PER] = per_q;
        end
        BASE_LSB'(OFS_STATUS): begin
          io_rdata[BIT_SW]  = sts_q.sw;
          io_rdata[BIT_PER] = sts_q.per;
          io_rdata[BIT_FL]  = sts_q.fl;
        end
        BASE_LSB'(OFS_PERIOD): io_rdata[DIV_W-1:0] = div_q;
        default: io_rdata = '0;
      endcase
    end
  end

  assign glb_en = glb_q;
  assign per_en = per_q;
  assign period = div_q;

  logic unused_io;
  assign unused_io = ^{io_wdata[DATA_W-1:DIV_W]};
endmodule

// File: rtl/smi_periodic.sv
module smi_periodic #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] period,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_nx;

  // >= keeps the divider safe when the period is lowered mid-count
  assign tick = en && (cnt_q >= period);

  always_comb begin
    if (!en)       cnt_nx = '0;
    else if (tick) cnt_nx = '0;
    else           cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/smi_req_ctl.sv
module smi_req_ctl
  import smi_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     glb_en,
  input  smi_src_t events,
  input  logic     smm_ack,
  output logic     fire,
  output logic     smi_req
);
  logic req_q, req_nx;

  assign fire = glb_en && (|events);

  // a new event outranks the acknowledge
  always_comb begin
    req_nx = req_q;
    if (smm_ack) req_nx = 1'b0;
    if (fire)    req_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_nx;
  end

  assign smi_req = req_q;
endmodule

// File: rtl/smi_gen_ctrl.sv
module smi_gen_ctrl
  import smi_gen_pkg::*;
#(
  parameter int               IO_AW    = 16,
  parameter int               BASE_LSB = 7,
  parameter int               DATA_W   = 32,
  parameter int               DIV_W    = 16,
  parameter logic [DIV_W-1:0] PER_RST  = '1,
  parameter logic [IO_AW-1:0] SWPORT   = 16'h00B2,
  parameter int               SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              smm_ack,
  input  logic              smm_active,
  output logic              smi_req,
  output logic              flash_wr_ok
);
  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[SYNC_N-1];

  logic [IO_AW-1:BASE_LSB] pm_base;
  logic                    smi_lock, fl_wren, fl_smm_only, fl_attempt;
  logic                    glb_en, per_en, per_tick, fire;
  logic [DIV_W-1:0]        period;
  smi_src_t                events;

  smi_cfg_regs #(.IO_AW(IO_AW), .BASE_LSB(BASE_LSB), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_i),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pm_base(pm_base), .smi_lock(smi_lock), .fl_wren(fl_wren),
    .fl_smm_only(fl_smm_only), .fl_attempt(fl_attempt)
  );

  smi_io_regs #(.IO_AW(IO_AW), .BASE_LSB(BASE_LSB), .DATA_W(DATA_W), .DIV_W(DIV_W),
                .PER_RST(PER_RST), .SWPORT(SWPORT)) u_io (
    .clk(clk), .rst_n(rst_n_i),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pm_base(pm_base), .smi_lock(smi_lock), .fl_attempt(fl_attempt), .per_tick(per_tick),
    .glb_en(glb_en), .per_en(per_en), .period(period), .events(events)
  );

  smi_periodic #(.DIV_W(DIV_W)) u_per (
    .clk(clk), .rst_n(rst_n_i), .en(per_en), .period(period), .tick(per_tick)
  );

  smi_req_ctl u_req (
    .clk(clk), .rst_n(rst_n_i), .glb_en(glb_en), .events(events),
    .smm_ack(smm_ack), .fire(fire), .smi_req(smi_req)
  );

  assign flash_wr_ok = fl_wren && (!fl_smm_only || smm_active);
endmodule

// File: rtl/smi_gen_ctrl_chk.sv
module smi_gen_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic smi_req,
  input logic smm_ack,
  input logic smm_active,
  input logic fire,
  input logic glb_en,
  input logic smi_lock,
  input logic fl_smm_only,
  input logic flash_wr_ok
);
  p_gated_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !smi_req) |=> !smi_req);

  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_req) |-> $past(fire));

  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && !smm_ack) |=> smi_req);

  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && smm_ack && !fire) |=> !smi_req);

  p_race_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_ack && fire) |=> smi_req);

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smi_lock |=> smi_lock);

  p_glb_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smi_lock |=> $stable(glb_en));

  p_smm_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_smm_only && !smm_active) |-> !flash_wr_ok);
endmodule

bind smi_gen_ctrl smi_gen_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .smm_ack(smm_ack),
  .smm_active(smm_active), .fire(fire), .glb_en(glb_en), .smi_lock(smi_lock),
  .fl_smm_only(fl_smm_only), .flash_wr_ok(flash_wr_ok)
);

// File: tb/test_smi_gen_ctrl.sv
module test_smi_gen_ctrl;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        io_wr;
  logic [15:0] io_addr;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;
  logic        smm_ack;
  logic        smm_active;
  logic        smi_req;
  logic        flash_wr_ok;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  smi_gen_ctrl i_smi_gen_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .smm_ack(smm_ack), .smm_active(smm_active), .smi_req(smi_req), .flash_wr_ok(flash_wr_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [31:0] d);
    io_addr = a; #1; d = io_rdata;
  endtask

  task automatic ack_pulse();
    @(negedge clk); smm_ack = 1'b1;
    @(negedge clk); smm_ack = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 smi_req", {31'b0, smi_req}, 32'd0);
    chk("R1 flash_wr_ok", {31'b0, flash_wr_ok}, 32'd0);
    io_read(16'h0030, d);  chk("R1 enable", d, 32'h7);
    io_read(16'h0034, d);  chk("R1 status", d, 32'h0);
    cfg_read(8'h40, d);    chk("R1 base", d, 32'h0);
    cfg_read(8'hA0, d);    chk("R1 lock", d, 32'h0);
    cfg_read(8'hDC, d);    chk("R1 flash ctl", d, 32'h0);
    io_write(16'h0030, 32'h3);
  endtask

  // R2
  task automatic t_base();
    logic [31:0] d;
    cfg_write(8'h40, 32'h1000);
    cfg_read(8'h40, d);      chk("R2 base readback", d, 32'h1000);
    io_write(16'h0030, 32'h0);
    io_read(16'h1030, d);    chk("R2 old window ignored", d, 32'h3);
    io_read(16'h0030, d);    chk("R2 old window reads 0", d, 32'h0);
    io_write(16'h1038, 32'h4);
    io_read(16'h1038, d);    chk("R2 divider", d, 32'h4);
  endtask

  // R4
  task automatic t_swport();
    logic [31:0] d;
    io_write(16'h00B2, 32'h55);
    chk("R4 req after port write", {31'b0, smi_req}, 32'd1);
    io_read(16'h1034, d);  chk("R4 status sw", d, 32'h2);
    ack_pulse();
    chk("R8 req drops on ack", {31'b0, smi_req}, 32'd0);
    io_write(16'h1034, 32'hE);
    io_write(16'h1030, 32'h1);
    io_write(16'h00B2, 32'h0);
    chk("R4 disabled no req", {31'b0, smi_req}, 32'd0);
    io_read(16'h1034, d);  chk("R4 disabled no status", d, 32'h0);
    io_write(16'h1030, 32'h3);
  endtask

  // R3
  task automatic t_global_off();
    logic [31:0] d;
    int seen = 0;
    io_write(16'h1030, 32'h6);
    io_write(16'h00B2, 32'h0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (smi_req) seen++;
    end
    chk("R3 no req while global off", seen, 0);
    io_read(16'h1034, d);  chk("R3 status still recorded", d, 32'h6);
    io_write(16'h1030, 32'h3);
    io_write(16'h1034, 32'hE);
  endtask

  // R5
  task automatic t_periodic();
    logic [31:0] d;
    int t1 = -1;
    int t2 = -1;
    io_write(16'h1030, 32'h5);
    for (int i = 0; i < 40 && t2 < 0; i++) begin
      @(negedge clk);
      io_read(16'h1034, d);
      if (d[2]) begin
        if (t1 < 0) begin
          t1 = cyc;
          io_write(16'h1034, 32'h4);
        end else begin
          t2 = cyc;
        end
      end
    end
    chk("R5 period P+1", t2 - t1, 5);
    chk("R5 periodic req", {31'b0, smi_req}, 32'd1);
    io_write(16'h1030, 32'h1);
    io_write(16'h1034, 32'hE);
    ack_pulse();
    repeat (30) @(negedge clk);
    io_read(16'h1034, d);  chk("R5 disabled no status", d, 32'h0);
    chk("R5 disabled no req", {31'b0, smi_req}, 32'd0);
    io_write(16'h1030, 32'h3);
  endtask

  // R6 and R10
  task automatic t_flash();
    logic [31:0] d;
    cfg_write(8'hDC, 32'h1);
    chk("R6 req on attempt", {31'b0, smi_req}, 32'd1);
    io_read(16'h1034, d);  chk("R6 status flash", d, 32'h8);
    cfg_read(8'hDC, d);    chk("R6 bit set", d, 32'h1);
    chk("R10 ok no protect", {31'b0, flash_wr_ok}, 32'd1);
    ack_pulse();
    cfg_write(8'hDC, 32'h0);
    cfg_read(8'hDC, d);    chk("R6 handler clears", d, 32'h0);
    chk("R10 off when clear", {31'b0, flash_wr_ok}, 32'd0);
    io_write(16'h1034, 32'hE);
    io_write(16'h1030, 32'h2);
    cfg_write(8'hDC, 32'h1);
    chk("R6 no req global off", {31'b0, smi_req}, 32'd0);
    cfg_read(8'hDC, d);    chk("R6 bit sticks", d, 32'h1);
    io_read(16'h1034, d);  chk("R6 status global off", d, 32'h8);
    cfg_write(8'hDC, 32'h3);
    smm_active = 1'b0; #1;
    chk("R10 protect outside SMM", {31'b0, flash_wr_ok}, 32'd0);
    smm_active = 1'b1; #1;
    chk("R10 protect inside SMM", {31'b0, flash_wr_ok}, 32'd1);
    smm_active = 1'b0;
    cfg_write(8'hDC, 32'h0);
    io_write(16'h1034, 32'hE);
    io_write(16'h1030, 32'h3);
  endtask

  // R8
  task automatic t_ack_race();
    io_write(16'h00B2, 32'h0);
    chk("R8 req up", {31'b0, smi_req}, 32'd1);
    @(negedge clk);
    smm_ack = 1'b1; io_addr = 16'h00B2; io_wr = 1'b1;
    @(negedge clk);
    smm_ack = 1'b0; io_wr = 1'b0;
    chk("R8 event beats ack", {31'b0, smi_req}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 level holds", {31'b0, smi_req}, 32'd1);
    ack_pulse();
    chk("R8 ack clears", {31'b0, smi_req}, 32'd0);
    io_write(16'h1034, 32'hE);
  endtask

  // R9
  task automatic t_w1c_race();
    logic [31:0] d;
    @(negedge clk);
    cfg_addr = 8'hDC; cfg_wdata = 32'h1; cfg_wr = 1'b1;
    io_addr = 16'h1034; io_wdata = 32'h8; io_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; io_wr = 1'b0;
    io_read(16'h1034, d);  chk("R9 set beats clear", d, 32'h8);
    io_write(16'h1034, 32'h0);
    io_read(16'h1034, d);  chk("R9 write 0 no effect", d, 32'h8);
    io_write(16'h1034, 32'h8);
    io_read(16'h1034, d);  chk("R9 write 1 clears", d, 32'h0);
    cfg_write(8'hDC, 32'h0);
    ack_pulse();
  endtask

  // R7
  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    io_write(16'h0030, 32'h3);
    cfg_write(8'hA0, 32'h10);
    cfg_read(8'hA0, d);    chk("R7 lock set", d, 32'h10);
    io_write(16'h0030, 32'h2);
    io_read(16'h0030, d);  chk("R7 global frozen on", d, 32'h3);
    io_write(16'h0030, 32'h0);
    io_read(16'h0030, d);  chk("R7 other bits writable", d, 32'h1);
    cfg_write(8'hA0, 32'h0);
    cfg_read(8'hA0, d);    chk("R7 lock not clearable", d, 32'h10);
    do_reset();
    cfg_read(8'hA0, d);    chk("R7 reset clears lock", d, 32'h0);
    io_write(16'h0030, 32'h2);
    cfg_write(8'hA0, 32'h10);
    io_write(16'h0030, 32'h3);
    io_read(16'h0030, d);  chk("R7 global frozen off", d, 32'h2);
    io_write(16'h00B2, 32'h0);
    chk("R7 frozen off no req", {31'b0, smi_req}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    io_wr = 1'b0; io_addr = '0; io_wdata = '0; smm_ack = 1'b0; smm_active = 1'b0;
    t_reset();
    t_base();
    t_swport();
    t_global_off();
    t_periodic();
    t_flash();
    t_ack_race();
    t_w1c_race();
    t_lock();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule